// File: doc/BRIEF.md
# CompactFlash LBA Sector Read Sequencer

This block supplies a stream of 16-bit words read from a CompactFlash card that runs in true-IDE mode. Each word is produced with ATA PIO register accesses. A host first loads a 28-bit logical block address as two halves, then pulls words one at a time. When no sector is buffered in the card, the sequencer runs two steps before it reads. First it empties any data the card still holds for an earlier command, using dummy reads of the data register. It then waits until the card accepts a command, writes a one-sector read command at the latched address, and polls status until the card offers data. Once a sector is buffered, 256 words are read straight from the data register with no status traffic between them.

Card accesses go through an external register-access engine. The handshake with it is request, address, write flag, write data, read data and a one-cycle done. When the card reports an error, the sequencer gives a one-cycle error pulse. It then soft-resets the card through the device control register, forgets all buffered state and retries the word that was pending.

The word output is a valid/ready source driven by demand. A fetch starts only when the consumer holds `out_ready` high while no word is waiting. A fetch that has started runs to completion. The word it produces stays on `out_data` with `out_valid` high until a cycle in which `out_ready` is high. No new fetch begins in that cycle.

Top module: `cf_sector_reader`

## Requirements
- R1: After reset `out_valid`, `reg_req` and `err_pulse` are low, and no register access starts until `out_ready` is raised.
- R2: A sector command is seven register writes in this order, using the register address codes feature=1, sector count=2, LBA low=3, LBA mid=4, LBA high=5, device/head=6, command=7. The data written is 0x00, 0x01, LBA[7:0], LBA[15:8], LBA[23:16], device/head, and 0x20. The host loads LBA[15:0] with `lba_sel`=0 and LBA[27:16] from `lba_data[11:0]` with `lba_sel`=1.
- R3: The device/head byte is 0xE0 ORed with LBA[27:24].
- R4: Status is read at address 7, and its low byte is decoded. Bit 0 set means error, and this test comes before the others. Data is offered when status AND 0xC9 equals 0x48. A command is accepted when status AND 0xC1 equals 0x40. Any other value causes status to be read again.
- R5: After a command, status is polled until data is offered. Then 256 words are read from the data register (address 0) with no status reads between them. Each word appears on `out_data` exactly as read.
- R6: A request made after the 256th word of a sector starts a new command.
- R7: Before a command is written, the sequencer reads status. While data is still offered, it does one dummy data read per status read. A command is written only once the card reports that it accepts a command.
- R8: On error, `err_pulse` is high for one cycle. The sequencer then writes 0x04 and later 0x00 to the device control register (address 0xE), with at least `RESET_WAIT` cycles between the two writes. After that it fetches the pending word again, starting with a new command.
- R9: Any write of the LBA marks the buffered sector as gone, so the next request drains and issues a new command even when the address is unchanged.
- R10: A word is held, with `out_data` stable, while `out_ready` is low. Once it is accepted, no new fetch begins until `out_ready` is high again while no word is waiting.
- R11: `reg_req` stays high with address, write flag and write data stable until `reg_done` arrives. It is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lba_we | input | 1 | Write one LBA half |
| lba_sel | input | 1 | 0 selects LBA[15:0], 1 selects LBA[27:16] |
| lba_data | input | 16 | LBA half value |
| out_valid | output | 1 | A word is waiting |
| out_ready | input | 1 | Consumer requests or accepts a word |
| out_data | output | 16 | Word from the card |
| reg_req | output | 1 | Register access request |
| reg_wr | output | 1 | 1 for a write, 0 for a read |
| reg_addr | output | 4 | Register address code |
| reg_wdata | output | 16 | Write data, with the low byte used for taskfile registers |
| reg_rdata | input | 16 | Read data, valid together with `reg_done` |
| reg_done | input | 1 | One-cycle completion of the access |
| err_pulse | output | 1 | One-cycle pulse on each detected card error |

## Verification
The assertions check the following on every cycle. A held register request keeps a stable address and data until done, and drops right after it. A waiting word stays stable under back-pressure. The error output lasts a single cycle. No register access runs while a word is waiting. Every device/head write carries the LBA-mode bits, and every command write carries the read code. The bench scenarios are needed to show the rest: the order of the command writes, the count of dummy reads before a new command, the absence of status polling inside a sector, the status decode (including busy with DRQ, and ERR with DRQ), the soft-reset spacing, and the retry after an error.

// File: rtl/cfsr_pkg.sv
package cfsr_pkg;
  localparam int WORD_W = 16;
  localparam int ADDR_W = 4;
  localparam int STEP_W = 3;
  localparam int NUM_STEPS = 7;

  localparam logic [ADDR_W-1:0] RA_DATA   = 4'h0;
  localparam logic [ADDR_W-1:0] RA_FEAT   = 4'h1;
  localparam logic [ADDR_W-1:0] RA_SCNT   = 4'h2;
  localparam logic [ADDR_W-1:0] RA_LBA0   = 4'h3;
  localparam logic [ADDR_W-1:0] RA_LBA1   = 4'h4;
  localparam logic [ADDR_W-1:0] RA_LBA2   = 4'h5;
  localparam logic [ADDR_W-1:0] RA_DEVHD  = 4'h6;
  localparam logic [ADDR_W-1:0] RA_CMDST  = 4'h7;
  localparam logic [ADDR_W-1:0] RA_DEVCTL = 4'hE;

  localparam logic [7:0] CMD_READ1  = 8'h20;
  localparam logic [7:0] CTL_SRST   = 8'h04;
  localparam logic [7:0] CTL_IDLE   = 8'h00;
  localparam logic [7:0] MASK_XFER  = 8'hC9;
  localparam logic [7:0] MATCH_XFER = 8'h48;
  localparam logic [7:0] MASK_CMD   = 8'hC1;
  localparam logic [7:0] MATCH_CMD  = 8'h40;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DRAIN_STAT,
    ST_DRAIN_READ,
    ST_ISSUE,
    ST_POLL,
    ST_FETCH,
    ST_SRST_ON,
    ST_SRST_WAIT,
    ST_SRST_OFF
  } seq_state_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [7:0]        data;
  } reg_write_t;

  function automatic reg_write_t issue_step(input logic [STEP_W-1:0] idx,
                                            input logic [27:0] lba);
    reg_write_t w;
    case (idx)
      3'd0:    w = '{addr: RA_FEAT,  data: 8'h00};
      3'd1:    w = '{addr: RA_SCNT,  data: 8'h01};
      3'd2:    w = '{addr: RA_LBA0,  data: lba[7:0]};
      3'd3:    w = '{addr: RA_LBA1,  data: lba[15:8]};
      3'd4:    w = '{addr: RA_LBA2,  data: lba[23:16]};
      3'd5:    w = '{addr: RA_DEVHD, data: {4'hE, lba[27:24]}};
      default: w = '{addr: RA_CMDST, data: CMD_READ1};
    endcase
    return w;
  endfunction
endpackage

// File: rtl/cfsr_lba_reg.sv
module cfsr_lba_reg
  import cfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              sel,
  input  logic [WORD_W-1:0] din,
  output logic [27:0]       lba
);
  localparam int HI_W = 28 - WORD_W;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lba <= '0;
    end else if (we) begin
      if (sel) lba[27:WORD_W] <= din[HI_W-1:0];
      else     lba[WORD_W-1:0] <= din;
    end
  end
endmodule

// File: rtl/cfsr_status_dec.sv
module cfsr_status_dec
  import cfsr_pkg::*;
(
  input  logic [7:0] status,
  output logic       is_err,
  output logic       xfer_ok,
  output logic       cmd_ok
);
  always_comb begin
    is_err  = status[0];
    xfer_ok = !is_err && ((status & MASK_XFER) == MATCH_XFER);
    cmd_ok  = !is_err && !xfer_ok && ((status & MASK_CMD) == MATCH_CMD);
  end
endmodule

// File: rtl/cfsr_word_ctr.sv
module cfsr_word_ctr #(
  parameter int WORDS = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [CW-1:0] FULL = CW'(WORDS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n)                    left <= '0;
    else if (load)                 left <= FULL;
    else if (dec && left != '0)    left <= left - ONE;
  end

  assign last = (left == ONE);
endmodule

// File: rtl/cf_sector_reader.sv
module cf_sector_reader
  import cfsr_pkg::*;
#(
  parameter int WORDS_PER_SECTOR = 256,
  parameter int RESET_WAIT       = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lba_we,
  input  logic              lba_sel,
  input  logic [WORD_W-1:0] lba_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              reg_req,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  input  logic [WORD_W-1:0] reg_rdata,
  input  logic              reg_done,
  output logic              err_pulse
);
  localparam int TW = $clog2(RESET_WAIT + 1);
  localparam logic [TW-1:0] T_END = TW'(RESET_WAIT - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_t        state;
  logic [STEP_W-1:0] step;
  logic [TW-1:0]     tmr;
  logic              sect_avail;
  logic [27:0]       lba;
  logic              st_err, st_xfer, st_cmd;
  logic              ctr_load, ctr_dec, ctr_last;
  logic              acc_done;
  logic              need_acc;
  reg_write_t        cur_step;

  cfsr_lba_reg u_lba (
    .clk(clk), .rst_n(rst_n), .we(lba_we), .sel(lba_sel), .din(lba_data), .lba(lba)
  );

  cfsr_status_dec u_dec (
    .status(reg_rdata[7:0]), .is_err(st_err), .xfer_ok(st_xfer), .cmd_ok(st_cmd)
  );

  cfsr_word_ctr #(.WORDS(WORDS_PER_SECTOR)) u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .dec(ctr_dec), .last(ctr_last)
  );

  assign acc_done = reg_req && reg_done;
  assign ctr_load = acc_done && (state == ST_POLL) && st_xfer;
  assign ctr_dec  = acc_done && (state == ST_FETCH);
  assign cur_step = issue_step(step, lba);

  always_comb begin
    need_acc  = 1'b1;
    reg_wr    = 1'b0;
    reg_addr  = RA_CMDST;
    reg_wdata = '0;
    case (state)
      ST_DRAIN_STAT, ST_POLL: reg_addr = RA_CMDST;
      ST_DRAIN_READ, ST_FETCH: reg_addr = RA_DATA;
      ST_ISSUE: begin
        reg_wr    = 1'b1;
        reg_addr  = cur_step.addr;
        reg_wdata = {8'h00, cur_step.data};
      end
      ST_SRST_ON: begin
        reg_wr    = 1'b1;
        reg_addr  = RA_DEVCTL;
        reg_wdata = {8'h00, CTL_SRST};
      end
      ST_SRST_OFF: begin
        reg_wr    = 1'b1;
        reg_addr  = RA_DEVCTL;
        reg_wdata = {8'h00, CTL_IDLE};
      end
      default: need_acc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        reg_req <= 1'b0;
    else if (reg_done) reg_req <= 1'b0;
    else if (need_acc) reg_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step       <= '0;
      tmr        <= '0;
      sect_avail <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      err_pulse  <= 1'b0;
    end else begin
      err_pulse <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (out_ready && !out_valid)
            state <= sect_avail ? ST_FETCH : ST_DRAIN_STAT;
        end
        ST_DRAIN_STAT: if (acc_done) begin
          if (st_err) begin
            err_pulse  <= 1'b1;
            sect_avail <= 1'b0;
            state      <= ST_SRST_ON;
          end else if (st_xfer) begin
            state <= ST_DRAIN_READ;
          end else if (st_cmd) begin
            step  <= '0;
            state <= ST_ISSUE;
          end
        end
        ST_DRAIN_READ: if (acc_done) state <= ST_DRAIN_STAT;
        ST_ISSUE: if (acc_done) begin
          if (step == LAST_STEP) state <= ST_POLL;
          else                   step  <= step + 1'b1;
        end
        ST_POLL: if (acc_done) begin
          if (st_err) begin
            err_pulse  <= 1'b1;
            sect_avail <= 1'b0;
            state      <= ST_SRST_ON;
          end else if (st_xfer) begin
            sect_avail <= 1'b1;
            state      <= ST_FETCH;
          end
        end
        ST_FETCH: if (acc_done) begin
          out_data  <= reg_rdata;
          out_valid <= 1'b1;
          if (ctr_last) sect_avail <= 1'b0;
          state <= ST_IDLE;
        end
        ST_SRST_ON: if (acc_done) begin
          tmr   <= '0;
          state <= ST_SRST_WAIT;
        end
        ST_SRST_WAIT: begin
          if (tmr == T_END) state <= ST_SRST_OFF;
          else              tmr   <= tmr + 1'b1;
        end
        ST_SRST_OFF: if (acc_done) begin
          sect_avail <= 1'b0;
          state      <= ST_DRAIN_STAT;
        end
        default: state <= ST_IDLE;
      endcase
      if (lba_we) sect_avail <= 1'b0;
    end
  end
endmodule

// File: rtl/cfsr_checker.sv
module cfsr_checker
  import cfsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              reg_req,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [WORD_W-1:0] reg_wdata,
  input logic              reg_done,
  input logic              err_pulse
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_done |=> reg_req && $stable(reg_addr) && $stable(reg_wr) && $stable(reg_wdata));

  // R11
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_done |=> !reg_req);

  // R10
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  quiet_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && reg_req));

  // R8
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  // R3
  devhead_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_wr && reg_addr == RA_DEVHD |-> reg_wdata[7:4] == 4'hE);

  // R2
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_wr && reg_addr == RA_CMDST |-> reg_wdata[7:0] == CMD_READ1);
endmodule

bind cf_sector_reader cfsr_checker u_cfsr_checker (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_done(reg_done), .err_pulse(err_pulse)
);

// File: tb/tb_cf_sector_reader.sv
`timescale 1ns/1ps
module tb_cf_sector_reader;
  localparam int RESET_WAIT = 200;

  logic clk = 0;
  logic rst_n = 0;
  logic lba_we = 0, lba_sel = 0;
  logic [15:0] lba_data = '0;
  logic out_valid, out_ready = 0;
  logic [15:0] out_data;
  logic reg_req, reg_wr;
  logic [3:0] reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata = '0;
  logic reg_done = 0;
  logic err_pulse;

  always #2.5 clk = ~clk;

  cf_sector_reader #(.WORDS_PER_SECTOR(256), .RESET_WAIT(RESET_WAIT)) dut (
    .clk(clk), .rst_n(rst_n), .lba_we(lba_we), .lba_sel(lba_sel), .lba_data(lba_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_done(reg_done), .err_pulse(err_pulse)
  );

  int checks = 0, errors = 0, delivered = 0;
  bit finished = 0;

  // card model state
  int cyc = 0;
  bit busy = 0;
  int wait_c = 0;
  int busy_left = 0, drq_left = 0, m_idx = 0;
  bit busy_phase = 0, inj = 0;
  logic [7:0] m_lba0 = '0, lat_lba0 = '0;
  int status_reads = 0, data_reads = 0, cmd_count = 0, seq_pos = 0;
  int cmd_bad = 0, cmd_while_drq = 0, early_reads = 0, err_pulses = 0;
  int devctrl_n = 0;
  int devctrl_t[4];
  int devctrl_v[4];
  logic [27:0] exp_lba = '0;

  function automatic logic [11:0] exp_write(input int pos, input logic [27:0] a);
    case (pos)
      0: return {4'h1, 8'h00};
      1: return {4'h2, 8'h01};
      2: return {4'h3, a[7:0]};
      3: return {4'h4, a[15:8]};
      4: return {4'h5, a[23:16]};
      5: return {4'h6, 8'hE0 | {4'h0, a[27:24]}};
      default: return {4'h7, 8'h20};
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst_n && err_pulse) err_pulses++;
    if (!rst_n) begin
      reg_done <= 0;
      busy = 0;
    end else if (reg_done) begin
      reg_done <= 0;
      busy = 0;
    end else if (reg_req && !busy) begin
      busy = 1;
      wait_c = 1;
    end else if (busy) begin
      if (wait_c > 0) wait_c--;
      else begin
        if (reg_wr) begin
          if (reg_addr == 4'hE) begin
            if (devctrl_n < 4) begin
              devctrl_t[devctrl_n] = cyc;
              devctrl_v[devctrl_n] = int'(reg_wdata[7:0]);
            end
            devctrl_n++;
            if (reg_wdata[7:0] == 8'h00) begin
              drq_left = 0; busy_left = 0; busy_phase = 0; seq_pos = 0;
            end
          end else begin
            if ({reg_addr, reg_wdata[7:0]} != exp_write(seq_pos, exp_lba)) cmd_bad++;
            if (reg_addr == 4'h3) lat_lba0 = reg_wdata[7:0];
            seq_pos++;
            if (seq_pos == 7) begin
              seq_pos = 0;
              cmd_count++;
              if (drq_left > 0) cmd_while_drq++;
              busy_left = 2; drq_left = 256; m_idx = 0;
              busy_phase = 1; m_lba0 = lat_lba0;
            end
          end
        end else if (reg_addr == 4'h7) begin
          status_reads++;
          if (inj) begin inj = 0; reg_rdata <= 16'h0059; end
          else if (busy_left == 2) begin busy_left--; reg_rdata <= 16'h0080; end
          else if (busy_left == 1) begin busy_left--; reg_rdata <= 16'h00D8; end
          else if (drq_left > 0) begin busy_phase = 0; reg_rdata <= 16'h0058; end
          else reg_rdata <= 16'h0050;
        end else begin
          data_reads++;
          if (busy_phase || drq_left == 0) early_reads++;
          reg_rdata <= {m_lba0, m_idx[7:0]};
          m_idx++;
          if (drq_left > 0) drq_left--;
        end
        reg_done <= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_lba(input logic [27:0] a);
    @(negedge clk);
    lba_we = 1; lba_sel = 0; lba_data = a[15:0];
    @(negedge clk);
    lba_sel = 1; lba_data = {4'h0, a[27:16]};
    @(negedge clk);
    lba_we = 0;
    exp_lba = a;
  endtask

  task automatic fetch(output logic [15:0] w);
    @(negedge clk);
    out_ready = 1;
    while (!out_valid) @(negedge clk);
    w = out_data;
    @(posedge clk);
    #1 out_ready = 0;
    delivered++;
  endtask

  // {lba, words to fetch, dummy reads expected before the command}
  localparam logic [47:0] TBL [4] = '{
    {28'h0123456, 10'd3,   10'd0},
    {28'hABCDEF1, 10'd256, 10'd253},
    {28'hFFFFFFF, 10'd2,   10'd0},
    {28'h8000000, 10'd1,   10'd254}
  };

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, held;
    int c0, d0, s0, a0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(out_valid == 0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(reg_req == 0, "R1 reg_req in reset", int'(reg_req), 0);
    rst_n = 1;
    repeat (8) @(negedge clk);
    chk(reg_req == 0 && out_valid == 0, "R1 idle without ready", int'(reg_req), 0);
    chk(err_pulse == 0, "R1 err_pulse idle", int'(err_pulse), 0);

    // table walk: R2 R3 R4 R5 R7 R9
    for (int e = 0; e < 4; e++) begin
      logic [27:0] a;
      int n, dr;
      a = TBL[e][47:20]; n = int'(TBL[e][19:10]); dr = int'(TBL[e][9:0]);
      write_lba(a);
      c0 = cmd_count; d0 = data_reads - delivered; s0 = 0;
      for (int k = 0; k < n; k++) begin
        fetch(w);
        if (k == 0) s0 = status_reads;
        chk(w == {a[7:0], k[7:0]}, "R5 word value", int'(w), int'({a[7:0], k[7:0]}));
      end
      chk(status_reads == s0, "R5 no status reads inside sector", status_reads, s0);
      chk(cmd_count == c0 + 1, "R9 one command per new LBA", cmd_count, c0 + 1);
      chk((data_reads - delivered) - d0 == dr, "R7 dummy drain count", (data_reads - delivered) - d0, dr);
    end
    chk(cmd_bad == 0, "R2 R3 command write order and values", cmd_bad, 0);
    chk(cmd_while_drq == 0, "R7 command only after drain", cmd_while_drq, 0);
    chk(early_reads == 0, "R4 no data read before DRQ status", early_reads, 0);

    // R6: request after 256th word starts a new command
    write_lba(28'h0C0FFEE);
    for (int k = 0; k < 256; k++) fetch(w);
    c0 = cmd_count; d0 = data_reads - delivered;
    fetch(w);
    chk(cmd_count == c0 + 1, "R6 new command after full sector", cmd_count, c0 + 1);
    chk(w == 16'hEE00, "R6 first word of new sector", int'(w), 16'hEE00);
    chk((data_reads - delivered) - d0 == 0, "R6 no drain after full sector", (data_reads - delivered) - d0, 0);

    // R9: rewriting the same LBA discards the buffered sector
    write_lba(28'h0C0FFEE);
    c0 = cmd_count; d0 = data_reads - delivered;
    fetch(w);
    chk(cmd_count == c0 + 1, "R9 same LBA forces new command", cmd_count, c0 + 1);
    chk((data_reads - delivered) - d0 == 255, "R9 R7 drain of 255", (data_reads - delivered) - d0, 255);
    chk(w == 16'hEE00, "R9 restart at word 0", int'(w), 16'hEE00);

    // R10: back-pressure
    @(negedge clk); out_ready = 1;
    while (!reg_req) @(negedge clk);
    out_ready = 0;
    while (!out_valid) @(negedge clk);
    held = out_data;
    a0 = status_reads + data_reads;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(out_valid == 1 && out_data == held, "R10 word held under back-pressure", int'(out_data), int'(held));
    end
    chk(held == 16'hEE01, "R10 held word value", int'(held), 16'hEE01);
    out_ready = 1;
    @(posedge clk); #1 out_ready = 0;
    delivered++;
    @(negedge clk);
    chk(out_valid == 0, "R10 word accepted", int'(out_valid), 0);
    repeat (6) @(negedge clk);
    chk(status_reads + data_reads == a0 && reg_req == 0, "R10 no fetch without ready", status_reads + data_reads, a0);

    // R8: error, soft reset, retry
    chk(err_pulses == 0, "R8 no error before injection", err_pulses, 0);
    write_lba(28'h0345678);
    inj = 1;
    c0 = cmd_count;
    fetch(w);
    chk(err_pulses == 1, "R8 one error pulse", err_pulses, 1);
    chk(devctrl_n == 2, "R8 two control writes", devctrl_n, 2);
    chk(devctrl_v[0] == 4 && devctrl_v[1] == 0, "R8 control values", devctrl_v[0] * 256 + devctrl_v[1], 16'h0400);
    chk(devctrl_t[1] - devctrl_t[0] >= RESET_WAIT, "R8 reset spacing", devctrl_t[1] - devctrl_t[0], RESET_WAIT);
    chk(cmd_count == c0 + 1, "R8 retry issues command", cmd_count, c0 + 1);
    chk(w == 16'h7800, "R8 retried word", int'(w), 16'h7800);
    chk(cmd_bad == 0, "R2 sequence still ordered", cmd_bad, 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule